// File: doc/BRIEF.md
# Serial/Parallel FIFO Entry Register

This block is the entry stage that sits in front of a fall-through data stack. It assembles one data word and then hands it to the stack. A word can arrive in either of two ways. It can be copied in parallel while a level-active load input is high. It can also be built up serially, one bit for each falling edge of a serial clock. All strobes come in asynchronously, so every one passes through a synchroniser on the system clock. The falling edges of the serial clock are found by comparing two samples in a row.

Fullness is tracked by a marker bit that rides along a chain of `DATA_W + 1` stages. When the marker reaches the last stage, the word is complete and the active-low full flag goes low. A transfer request (active low) offers the word to the stack on a valid/ready pair. The stack accepts it when its top slot is free. A one-shot latch records the hand-off, so the same word cannot be entered twice. The register then reinitialises once the parallel load is low.

The serial-enable level seen during reset picks the mode for chaining:
- **Master:** the enable is low during reset. Reinitialisation follows the transfer at once.
- **Slave:** the enable is high during reset. Reinitialisation waits until the enable goes low. In a chain, that enable comes from the full flag of the device of higher priority.

Top module: `fifoEntryReg`

## Requirements
- R1: After reset, `fullN` is 1, `stackValid` is 0, and `stackData` holds the empty pattern 0001: data bit 0 carries the marker and all other bits are 0.
- R2: While `loadPar` is high, `parData` is copied into `stackData` and `fullN` goes low.
- R3: While `serEnN` is low, each falling edge of `serClk` shifts `serData` in. After `DATA_W` edges, `fullN` goes low. The first bit sent lands in the MSB of `stackData`, and the last bit sent lands in bit 0.
- R4: Serial clock edges have no effect while `serEnN` is high. They also have no effect while a full word is held: `stackData` and `fullN` stay unchanged.
- R5: `stackValid` is high only when a full word is held and `xferN` is low (a request) and that word has not already been transferred. A transfer is one cycle with `stackValid` and `stackReady` both high.
- R6: Each word is transferred exactly once. After the transfer, `stackValid` stays low. The register is not reinitialised (`fullN` stays low) while `loadPar` is high.
- R7: In master mode, `fullN` returns high once the transfer is done and `loadPar` is low.
- R8: In slave mode, after a transfer, `fullN` stays low until `serEnN` goes low. It then returns high.
- R9: While `stackReady` is low, a requested word stays held: `stackValid` stays high, `fullN` stays low, and no transfer occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset; also samples the master/slave mode |
| loadPar | input | 1 | Parallel load, active high (asynchronous level) |
| parData | input | DATA_W | Parallel data word |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| serEnN | input | 1 | Serial enable, active low; slave reinitialisation gate |
| serData | input | 1 | Serial data bit |
| xferN | input | 1 | Transfer-to-stack request, active low |
| stackReady | input | 1 | Stack top slot is empty |
| stackValid | output | 1 | Word offered to the stack |
| stackData | output | DATA_W | Held word |
| fullN | output | 1 | Full flag, active low |

## Verification
Some properties are checked on every cycle:
- The chain never loses its marker.
- A held word stays frozen against serial shifts.
- Init, load and shift never fire together.
- A completed transfer never leaves the offer raised.
- The hand-off latch holds while the load is high.

The bench scenarios cover behaviour that depends on ordering: bit order in serial assembly, the empty pattern, the hold under back-pressure, and the different reinitialisation timing of master and slave. These come from stimulus sequences, not from single-cycle relations.

// File: rtl/fifoEntryPkg.sv
package fifoEntryPkg;
  typedef struct packed {
    logic init;
    logic load;
    logic shift;
  } entryStrobeT;
endpackage

// File: rtl/entrySync.sv
module entrySync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RESET_VAL;
      else if (s == 0) stage[s] <= asyncIn;
      else stage[s] <= stage[(s == 0) ? 0 : s - 1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/entryPath.sv
module entryPath
  import fifoEntryPkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryStrobeT       strobe,
  input  logic [DATA_W-1:0] parWord,
  input  logic              serBit,
  output logic              flag,
  output logic [DATA_W-1:0] word
);
  localparam int CHAIN_W = DATA_W + 1;
  localparam logic [CHAIN_W-1:0] EMPTY_PATTERN = CHAIN_W'(1);

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= EMPTY_PATTERN;
    else if (strobe.init) chain <= EMPTY_PATTERN;
    else if (strobe.load) chain <= {1'b1, parWord};
    else if (strobe.shift) chain <= {chain[DATA_W-1:0], serBit};
  end

  assign flag = chain[DATA_W];
  assign word = chain[DATA_W-1:0];

  // R3
  marker_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    chain != '0);

  // R4
  full_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strobe.init && !strobe.load) |=> $stable(chain));
endmodule

// File: rtl/entryCtrl.sv
module entryCtrl
  import fifoEntryPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rawSerEnN,
  input  logic        loadS,
  input  logic        serClkS,
  input  logic        serEnNS,
  input  logic        xferNS,
  input  logic        flag,
  input  logic        stackReady,
  output entryStrobeT strobe,
  output logic        stackValid
);
  logic masterLatch;
  logic prevSerClk;
  logic initLatch;
  logic serFall;
  logic xferDone;

  // mode is sampled while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) masterLatch <= ~rawSerEnN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSerClk <= 1'b0;
    else prevSerClk <= serClkS;
  end

  assign serFall    = prevSerClk & ~serClkS;
  assign stackValid = flag & ~xferNS & ~initLatch;
  assign xferDone   = stackValid & stackReady;

  always_comb begin
    strobe.init  = initLatch & ~loadS & (masterLatch | ~serEnNS);
    strobe.load  = loadS;
    strobe.shift = serFall & ~serEnNS & ~flag & ~loadS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initLatch <= 1'b0;
    else if (xferDone) initLatch <= 1'b1;
    else if (strobe.init) initLatch <= 1'b0;
  end

  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.init, strobe.load, strobe.shift}));

  // R6
  single_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stackValid && stackReady) |=> !stackValid);

  // R6
  hold_under_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initLatch && loadS) |=> initLatch);
endmodule

// File: rtl/fifoEntryReg.sv
module fifoEntryReg
  import fifoEntryPkg::*;
#(
  parameter int DATA_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadPar,
  input  logic [DATA_W-1:0] parData,
  input  logic              serClk,
  input  logic              serEnN,
  input  logic              serData,
  input  logic              xferN,
  input  logic              stackReady,
  output logic              stackValid,
  output logic [DATA_W-1:0] stackData,
  output logic              fullN
);
  localparam int CTL_W = 5;
  localparam logic [CTL_W-1:0] CTL_RESET = 5'b00110;

  logic [CTL_W-1:0] ctlSync;
  logic [DATA_W-1:0] parSync;
  entryStrobeT strobe;
  logic flag;

  entrySync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RESET_VAL(CTL_RESET)) i_ctlSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({serClk, loadPar, xferN, serEnN, serData}),
    .syncOut(ctlSync)
  );

  entrySync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RESET_VAL('0)) i_parSync (
    .clk(clk), .rstN(rstN), .asyncIn(parData), .syncOut(parSync)
  );

  entryCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .rawSerEnN(serEnN),
    .loadS(ctlSync[3]), .serClkS(ctlSync[4]), .serEnNS(ctlSync[1]),
    .xferNS(ctlSync[2]), .flag(flag), .stackReady(stackReady),
    .strobe(strobe), .stackValid(stackValid)
  );

  entryPath #(.DATA_W(DATA_W)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .parWord(parSync),
    .serBit(ctlSync[0]), .flag(flag), .word(stackData)
  );

  assign fullN = ~flag;
endmodule

// File: tb/test_fifoEntryReg.sv
module test_fifoEntryReg;
  logic clk = 1'b0;
  logic rstN, loadPar, serClk, serEnN, serData, xferN, stackReady;
  logic [3:0] parData;
  logic stackValid, fullN;
  logic [3:0] stackData;
  int errors = 0, checks = 0, xferCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fifoEntryReg i_fifoEntryReg (
    .clk(clk), .rstN(rstN), .loadPar(loadPar), .parData(parData),
    .serClk(serClk), .serEnN(serEnN), .serData(serData), .xferN(xferN),
    .stackReady(stackReady), .stackValid(stackValid), .stackData(stackData),
    .fullN(fullN)
  );

  always @(negedge clk) if (rstN && stackValid && stackReady) xferCount++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic master);
    @(negedge clk);
    rstN = 1'b0; loadPar = 0; parData = 0; serClk = 0; serData = 0;
    xferN = 1; stackReady = 0; serEnN = master ? 1'b0 : 1'b1;
    tick(4);
    rstN = 1'b1;
    tick(2);
    check("R1 fullN", fullN, 1);
    check("R1 stackValid", stackValid, 0);
    check("R1 empty pattern", stackData, 4'b0001);
  endtask

  task automatic serialBit(input logic b);
    serData = b; serClk = 1'b1; tick(3);
    serClk = 1'b0; tick(3);
  endtask

  task automatic masterParallel();
    int base;
    doReset(1'b1);
    parData = 4'hA; loadPar = 1; tick(5);
    check("R2 word", stackData, 4'hA);
    check("R2 fullN", fullN, 0);
    base = xferCount;
    stackReady = 1; xferN = 0; tick(8);
    check("R5 one transfer", xferCount - base, 1);
    check("R6 no reinit while load high", fullN, 0);
    check("R6 no second offer", stackValid, 0);
    loadPar = 0; tick(6);
    check("R7 master reinit", fullN, 1);
    check("R6 still one transfer", xferCount - base, 1);
    xferN = 1; tick(4);
  endtask

  task automatic masterSerial();
    int base;
    doReset(1'b1);
    serialBit(1); serialBit(0); serialBit(1); serialBit(1);
    check("R3 first bit is MSB", stackData, 4'hB);
    check("R3 fullN", fullN, 0);
    check("R5 no offer without request", stackValid, 0);
    serialBit(0); serialBit(0);
    check("R4 full ignores serial", stackData, 4'hB);
    base = xferCount;
    stackReady = 0; xferN = 0; tick(8);
    check("R9 offer held", stackValid, 1);
    check("R9 still full", fullN, 0);
    check("R9 no transfer", xferCount - base, 0);
    stackReady = 1; tick(6);
    check("R5 transfer", xferCount - base, 1);
    check("R7 master reinit", fullN, 1);
    xferN = 1; tick(4);
    serEnN = 1;
    serialBit(1); serialBit(1); serialBit(1); serialBit(1);
    check("R4 disabled serial", fullN, 1);
    check("R4 disabled data", stackData, 4'b0001);
  endtask

  task automatic slaveParallel();
    int base;
    doReset(1'b0);
    parData = 4'h5; loadPar = 1; tick(5); loadPar = 0; tick(4);
    check("R2 slave word", stackData, 4'h5);
    base = xferCount;
    stackReady = 1; xferN = 0; tick(10);
    check("R5 slave transfer", xferCount - base, 1);
    check("R8 waits for enable", fullN, 0);
    check("R6 no repeat", stackValid, 0);
    serEnN = 0; tick(6);
    check("R8 reinit after enable", fullN, 1);
    check("R6 one transfer only", xferCount - base, 1);
    xferN = 1; tick(3);
  endtask

  initial begin
    fork
      begin
        masterParallel();
        masterSerial();
        slaveParallel();
        finished = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          errors++; checks++;
          $display("FAIL watchdog: actual=timeout expected=done");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule